// File: doc/BRIEF.md
# High-Side Output Guard and Diagnostic Monitor

This block sits between the command register of an eight-channel high-side switch and the gate enables of its output stages. Each cycle it takes the requested on/off pattern, the sampled level of every output pin, a per-channel short-to-ground detect, a die over-temperature flag, a battery-present flag and a strobe that marks the end of a correctly framed serial transfer. It produces the final enable of every driver and one diagnostic bit per channel, which the serial interface captures for the host.

A diagnostic bit reports the real level of its output pin, not a fault flag. The host finds a fault by comparing the bit with the state it requested. A short to ground that persists for a set number of clock cycles turns its channel off. The channel stays off until the next valid frame. An over-temperature event switches every channel off and drives every diagnostic bit to the opposite of the requested state. The host therefore recognises a thermal shutdown when all eight bits disagree with its request at once. That condition persists until the die has cooled and a valid frame has been received.

Top module: `hsd_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `driveEn` and `diagBits` are all zero.
- R2: With no fault latched and the battery present, `driveEn` equals the `reqState` sampled at the previous clock edge.
- R3: With no thermal fault latched, `diagBits` equals the `outLevel` sampled at the previous clock edge (bit i = 1 when output i is high).
- R4: A channel requested on whose `shortDet` bit is high for `DEBOUNCE_CYCLES` consecutive clock edges is latched as shorted, and its `driveEn` bit is low from the following edge.
- R5: A short run shorter than `DEBOUNCE_CYCLES` edges, followed by a cycle with `shortDet` low, leaves the channel enabled; the count restarts from zero.
- R6: A shorted channel stays off, even after `shortDet` clears, until a `frameValid` pulse; after that pulse its enable follows `reqState` again and the debounce count starts over.
- R7: A clock edge with `thermTrip` high latches a thermal fault. From the next edge, all `driveEn` bits are 0 and each `diagBits` bit is the inverse of its `reqState` bit (0 for a channel requested on, 1 for a channel requested off).
- R8: The thermal fault stays latched after `thermTrip` falls. It clears only on an edge where `frameValid` is high and `thermTrip` is low; a `frameValid` pulse while `thermTrip` is high does not clear it.
- R9: While `batteryOk` is low, every `driveEn` bit is 0 from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqState | input | 8 | Requested on/off state per channel from the command register |
| outLevel | input | 8 | Sampled logic level of each output pin |
| shortDet | input | 8 | Per-channel short-to-ground detect |
| thermTrip | input | 1 | Die temperature above the trip point |
| batteryOk | input | 1 | Battery supply present |
| frameValid | input | 1 | One-cycle pulse at the end of a correctly framed serial transfer |
| driveEn | output | 8 | Final driver enables |
| diagBits | output | 8 | Diagnostic bits for the serial output register |

## Verification
The assertions assume that every input is synchronous to `clk` and that `frameValid` is a pulse, not a level held for many cycles. If the strobe were held high, a shorted channel would be released on every cycle, and the short-latch hold check would have nothing to observe. The stimulus changes inputs only on falling edges and raises `frameValid` for one cycle at a time. It holds `shortDet` steady across each debounce window, so the count of consecutive edges is exact. The expected values are derived from the requirements.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  parameter int unsigned CH_COUNT = 8;

  typedef struct packed {
    logic                thermHold;
    logic [CH_COUNT-1:0] shortOff;
  } guardStrobes_t;
endpackage

// File: rtl/hsd_debounce.sv
module hsd_debounce #(
  parameter int unsigned DEBOUNCE_CYCLES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic armed,
  input  logic shortSeen,
  input  logic clear,
  output logic tripped
);
  localparam int unsigned CNT_W = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt  <= '0;
      tripped <= 1'b0;
    end else if (clear) begin
      runCnt  <= '0;
      tripped <= 1'b0;
    end else if (tripped) begin
      runCnt  <= '0;
    end else if (armed && shortSeen) begin
      if (runCnt == LAST) begin
        tripped <= 1'b1;
        runCnt  <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end else begin
      runCnt <= '0;
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= LAST);

  // R6
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tripped && !clear) |=> tripped);

  // R5
  no_trip_when_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tripped && !(armed && shortSeen)) |=> !tripped);
endmodule

// File: rtl/hsd_ctrl.sv
module hsd_ctrl
  import hsd_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CH_COUNT-1:0] reqState,
  input  logic [CH_COUNT-1:0] shortDet,
  input  logic                thermTrip,
  input  logic                frameValid,
  output guardStrobes_t       strobes
);
  logic                thermLatch;
  logic [CH_COUNT-1:0] shortLatch;

  always_ff @(posedge clk) begin
    if (!rstN)           thermLatch <= 1'b0;
    else if (thermTrip)  thermLatch <= 1'b1;
    else if (frameValid) thermLatch <= 1'b0;
  end

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : gChan
    hsd_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) uDeb (
      .clk      (clk),
      .rstN     (rstN),
      .armed    (reqState[ch]),
      .shortSeen(shortDet[ch]),
      .clear    (frameValid),
      .tripped  (shortLatch[ch])
    );
  end

  assign strobes.thermHold = thermLatch;
  assign strobes.shortOff  = shortLatch;

  // R7
  therm_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    thermTrip |=> strobes.thermHold);

  // R8
  therm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.thermHold && !(frameValid && !thermTrip)) |=> strobes.thermHold);

  // R8
  therm_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !thermTrip) |=> !strobes.thermHold);
endmodule

// File: rtl/hsd_datapath.sv
module hsd_datapath
  import hsd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [CH_COUNT-1:0] reqState,
  input  logic [CH_COUNT-1:0] outLevel,
  input  logic                batteryOk,
  input  guardStrobes_t       strobes,
  output logic [CH_COUNT-1:0] driveEn,
  output logic [CH_COUNT-1:0] diagBits
);
  logic [CH_COUNT-1:0] allowMask;

  always_comb begin
    allowMask = ~strobes.shortOff;
    if (strobes.thermHold || !batteryOk) allowMask = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      driveEn  <= '0;
      diagBits <= '0;
    end else begin
      driveEn  <= reqState & allowMask;
      diagBits <= strobes.thermHold ? ~reqState : outLevel;
    end
  end

  // R7
  therm_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.thermHold |=> (driveEn == '0));

  // R7
  therm_diag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.thermHold |=> (diagBits == ~$past(reqState)));

  // R9
  battery_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !batteryOk |=> (driveEn == '0));

  // R3
  diag_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.thermHold |=> (diagBits == $past(outLevel)));

  // R4
  short_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shortOff != '0) |=> ((driveEn & $past(strobes.shortOff)) == '0));
endmodule

// File: rtl/hsd_guard.sv
module hsd_guard
  import hsd_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] reqState,
  input  logic [7:0] outLevel,
  input  logic [7:0] shortDet,
  input  logic       thermTrip,
  input  logic       batteryOk,
  input  logic       frameValid,
  output logic [7:0] driveEn,
  output logic [7:0] diagBits
);
  guardStrobes_t strobes;

  hsd_ctrl #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqState  (reqState),
    .shortDet  (shortDet),
    .thermTrip (thermTrip),
    .frameValid(frameValid),
    .strobes   (strobes)
  );

  hsd_datapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .reqState (reqState),
    .outLevel (outLevel),
    .batteryOk(batteryOk),
    .strobes  (strobes),
    .driveEn  (driveEn),
    .diagBits (diagBits)
  );
endmodule

// File: tb/sim_hsd_guard.sv
module sim_hsd_guard;
  localparam int unsigned DEB = 6;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] reqState, outLevel, shortDet;
  logic       thermTrip, batteryOk, frameValid;
  logic [7:0] driveEn, diagBits;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hsd_guard #(.DEBOUNCE_CYCLES(DEB)) u0 (
    .clk(clk), .rstN(rstN), .reqState(reqState), .outLevel(outLevel),
    .shortDet(shortDet), .thermTrip(thermTrip), .batteryOk(batteryOk),
    .frameValid(frameValid), .driveEn(driveEn), .diagBits(diagBits)
  );

  // {batteryOk, reqState, outLevel, expected driveEn, expected diagBits}
  localparam int NV = 6;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 8'hA5, 8'h5A, 8'hA5, 8'h5A},
    {1'b1, 8'hFF, 8'hFF, 8'hFF, 8'hFF},
    {1'b1, 8'h00, 8'h00, 8'h00, 8'h00},
    {1'b1, 8'h3C, 8'hC3, 8'h3C, 8'hC3},
    {1'b0, 8'hFF, 8'h00, 8'h00, 8'h00},
    {1'b1, 8'h81, 8'h7E, 8'h81, 8'h7E}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; reqState = 8'hFF; outLevel = 8'hFF; shortDet = 0;
    thermTrip = 0; batteryOk = 1; frameValid = 0;
    step(3);
    chk("R1 driveEn in reset", driveEn, 8'h00);
    chk("R1 diagBits in reset", diagBits, 8'h00);
    reqState = 8'h00; outLevel = 8'h00;
    rstN = 1;
    step(1);
    chk("R1 driveEn after reset", driveEn, 8'h00);

    // R2 R3 R9 table
    for (int i = 0; i < NV; i++) begin
      batteryOk = VEC[i][32];
      reqState  = VEC[i][31:24];
      outLevel  = VEC[i][23:16];
      step(1);
      chk(VEC[i][32] ? "R2 enable follows request" : "R9 battery missing", driveEn, VEC[i][15:8]);
      chk("R3 diag follows level", diagBits, VEC[i][7:0]);
    end
    batteryOk = 1;

    // R5: short one edge too short, then cleared
    reqState = 8'h0F; outLevel = 8'h0F;
    shortDet = 8'h01;
    step(DEB - 1);
    shortDet = 8'h00;
    step(1);
    shortDet = 8'h01;
    step(DEB - 1);
    shortDet = 8'h00;
    step(3);
    chk("R5 short below debounce keeps channel", driveEn, 8'h0F);

    // R4: full debounce window on channel 2
    shortDet = 8'h04;
    step(DEB);
    chk("R4 not off on latching edge", driveEn, 8'h0F);
    step(1);
    chk("R4 shorted channel off", driveEn, 8'h0B);
    shortDet = 8'h00;
    step(4);
    chk("R6 stays off after short clears", driveEn, 8'h0B);

    // R6: frame pulse releases
    frameValid = 1;
    step(1);
    frameValid = 0;
    step(1);
    chk("R6 frame releases shorted channel", driveEn, 8'h0F);

    // R7: thermal trip
    reqState = 8'h0F; outLevel = 8'h33;
    thermTrip = 1;
    step(2);
    chk("R7 thermal forces off", driveEn, 8'h00);
    chk("R7 diag fault state", diagBits, 8'hF0);
    thermTrip = 0;
    step(3);
    chk("R8 latch holds after cooling", driveEn, 8'h00);
    thermTrip = 1; frameValid = 1;
    step(1);
    frameValid = 0; thermTrip = 0;
    step(2);
    chk("R8 frame while hot does not clear", driveEn, 8'h00);
    chk("R8 diag still fault", diagBits, 8'hF0);
    frameValid = 1;
    step(1);
    frameValid = 0;
    step(1);
    chk("R8 cool frame clears enable", driveEn, 8'h0F);
    chk("R8 cool frame clears diag", diagBits, 8'h33);

    // R9 directed
    batteryOk = 0;
    step(1);
    chk("R9 battery loss drops all", driveEn, 8'h00);
    batteryOk = 1;
    step(1);
    chk("R2 battery back restores", driveEn, 8'h0F);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule